// File: doc/BRIEF.md
# Reloadable Baud Rate Generator

This block makes the bit-rate timing for a serial channel. A 13-bit timer counts down on a clock enable that fires on every second system clock. The enable is gated by a run input. When the timer steps past zero it sends out one pulse and loads itself again from a 13-bit reload register. The pulse stream can be thinned so that two of every three pulses pass. A final divider then produces a one-cycle bit-clock enable once every 16 pulses in asynchronous framing, or once every 4 in synchronous framing.

Software reaches the block through one 16-bit register port. A read returns the live timer value. A write changes only the reload value, and the running timer is left alone. The serial shifter that uses the bit-clock enable is outside this block.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the timer reads 0 and the reload value is 0. `ctr_pulse`, `thin_pulse` and `bit_tick` are low, and the thinning and final-divider phases are cleared.
- R2: While `run_en` is 1, the timer moves by one step every second system clock. With reload value R held constant, successive `ctr_pulse` assertions are 2*(R+1) clocks apart.
- R3: While `run_en` is 0, the timer keeps its value and `ctr_pulse` stays low.
- R4: Each underflow raises `ctr_pulse` for exactly one clock. An underflow is a step taken while the timer is 0, and that step loads the reload value.
- R5: With `thin_sel` = 0, `thin_pulse` equals `ctr_pulse` on every clock.
- R6: With `thin_sel` = 1, counting `ctr_pulse` assertions from the first one after `thin_sel` rose, the 1st and 2nd of each group of three reach `thin_pulse` and the 3rd is dropped.
- R7: `bit_tick` rises together with every 16th `thin_pulse` since reset when `sync_mode` = 0, and with every 4th when `sync_mode` = 1. It is high for one clock.
- R8: `reg_rdata[12:0]` shows the live timer and `reg_rdata[15:13]` always reads 0.
- R9: A clock with `reg_wr` = 1 loads `reg_wdata[12:0]` into the reload register and ignores `reg_wdata[15:13]`. The timer value is not changed. The new reload value takes effect at the next underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Lets the timer count when 1 |
| thin_sel | input | 1 | 1 passes two of every three timer pulses |
| sync_mode | input | 1 | 0 divides by 16 (asynchronous), 1 divides by 4 (synchronous) |
| reg_wr | input | 1 | Write strobe for the shared register |
| reg_wdata | input | 16 | Write data; bits 12:0 become the reload value |
| reg_rdata | output | 16 | Live timer value, zero-extended |
| ctr_pulse | output | 1 | One-clock pulse per timer underflow |
| thin_pulse | output | 1 | Timer pulses after the optional 2/3 thinning |
| bit_tick | output | 1 | One-clock bit-clock enable after the final divider |

## Verification
A wrong timer or reload value shows up within one timer period as a wrong spacing between `ctr_pulse` assertions. The bench measures that spacing for a sweep of reload values, from zero up to the full 13-bit maximum. A thinning phase that drifts breaks the pass-pass-drop pattern within three timer pulses. A wrong final-divider count moves `bit_tick` away from every 16th or every 4th thinned pulse within one divide cycle. A write that disturbs the timer can be seen at once on `reg_rdata` while counting is stopped.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

   // Default geometry of the generator
   localparam int unsigned DEF_CNT_W     = 13;
   localparam int unsigned DEF_BUS_W     = 16;
   localparam int unsigned DEF_PRE_DIV   = 2;
   localparam int unsigned DEF_ASYNC_DIV = 16;
   localparam int unsigned DEF_SYNC_DIV  = 4;

   // Framing mode seen by the final divider
   typedef enum logic [0:0] {
      FRAME_ASYNC = 1'b0,
      FRAME_SYNC  = 1'b1
   } frame_mode_e;

   // Counter width able to hold values 0..n-1 (at least one bit)
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/bg_prescale.sv
// Clock-enable prescaler: one tick every PRE_DIV enabled clocks.
module bg_prescale #(
   parameter int unsigned PRE_DIV = baudgen_pkg::DEF_PRE_DIV
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (PRE_DIV == 1) begin : g_direct
         // No prescaling: every enabled clock is a tick
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign tick_o = run_i;
      end else begin : g_count
         localparam int unsigned PW = baudgen_pkg::idx_w(PRE_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
         localparam logic [PW-1:0] ONE  = PW'(1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (run_i) begin
               if (phase_q == LAST) phase_q <= '0;
               else                 phase_q <= phase_q + ONE;
            end
         end

         assign tick_o = run_i && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/bg_downcnt.sv
// Down-counting timer with reload register; flags each underflow.
module bg_downcnt #(
   parameter int unsigned CNT_W = baudgen_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ld_we_i,
   input  logic [CNT_W-1:0] ld_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             uf_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic             uf_q;

   // The reload register changes only by a write; the live count is never touched by it.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
      end else if (ld_we_i) begin
         reload_q <= ld_val_i;
      end
   end

   // A step taken at zero is the underflow: reload and flag it.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         uf_q  <= 1'b0;
      end else begin
         uf_q <= 1'b0;
         if (tick_i) begin
            if (cnt_q == '0) begin
               cnt_q <= reload_q;
               uf_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   assign cnt_o = cnt_q;
   assign uf_o  = uf_q;
endmodule

// File: rtl/bg_thin.sv
// Optional 2/3 pulse thinning: passes two pulses, drops the third.
module bg_thin #(
   parameter bit THIN_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic pulse_i,
   output logic pulse_o
);
   generate
      if (THIN_EN) begin : g_thin
         logic [1:0] mod3_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mod3_q <= 2'd0;
            end else if (!sel_i) begin
               mod3_q <= 2'd0;
            end else if (pulse_i) begin
               mod3_q <= (mod3_q == 2'd2) ? 2'd0 : mod3_q + 2'd1;
            end
         end

         assign pulse_o = pulse_i && (!sel_i || (mod3_q != 2'd2));
      end else begin : g_pass
         logic unused_thin;
         assign unused_thin = clk ^ rst_n ^ sel_i;
         assign pulse_o = pulse_i;
      end
   endgenerate
endmodule

// File: rtl/bg_postdiv.sv
// Mode-dependent final divider producing a one-cycle bit-clock enable.
module bg_postdiv #(
   parameter int unsigned ASYNC_DIV = baudgen_pkg::DEF_ASYNC_DIV,
   parameter int unsigned SYNC_DIV  = baudgen_pkg::DEF_SYNC_DIV
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic pulse_i,
   output logic tick_o
);
   import baudgen_pkg::*;

   localparam int unsigned MAX_DIV = (ASYNC_DIV > SYNC_DIV) ? ASYNC_DIV : SYNC_DIV;
   localparam int unsigned DW = idx_w(MAX_DIV);
   localparam logic [DW-1:0] A_LAST = DW'(ASYNC_DIV - 1);
   localparam logic [DW-1:0] S_LAST = DW'(SYNC_DIV - 1);
   localparam logic [DW-1:0] ONE    = DW'(1);

   frame_mode_e   mode;
   logic [DW-1:0] last;
   logic [DW-1:0] div_q;
   logic          wrap;

   assign mode = frame_mode_e'(mode_i);
   assign last = (mode == FRAME_SYNC) ? S_LAST : A_LAST;
   // >= keeps the divider safe if the mode shrinks the limit mid-count
   assign wrap = (div_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (pulse_i) begin
         if (wrap) div_q <= '0;
         else      div_q <= div_q + ONE;
      end
   end

   assign tick_o = pulse_i && wrap;
endmodule

// File: rtl/baud_tick_gen.sv
// Reloadable baud rate generator: prescale, down-count, thin, divide.
module baud_tick_gen #(
   parameter int unsigned CNT_W     = baudgen_pkg::DEF_CNT_W,
   parameter int unsigned BUS_W     = baudgen_pkg::DEF_BUS_W,
   parameter int unsigned PRE_DIV   = baudgen_pkg::DEF_PRE_DIV,
   parameter int unsigned ASYNC_DIV = baudgen_pkg::DEF_ASYNC_DIV,
   parameter int unsigned SYNC_DIV  = baudgen_pkg::DEF_SYNC_DIV,
   parameter bit          THIN_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             thin_sel,
   input  logic             sync_mode,
   input  logic             reg_wr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   output logic             ctr_pulse,
   output logic             thin_pulse,
   output logic             bit_tick
);
   // Elaboration-time parameter checks
   generate
      if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_width
         $error("baud_tick_gen: CNT_W must be 1..BUS_W");
      end
      if (PRE_DIV < 1) begin : g_bad_pre
         $error("baud_tick_gen: PRE_DIV must be at least 1");
      end
      if (ASYNC_DIV < 2 || SYNC_DIV < 2) begin : g_bad_div
         $error("baud_tick_gen: final divisors must be at least 2");
      end
   endgenerate

   logic             step_tick;
   logic [CNT_W-1:0] cnt_val;
   logic             uf_pulse;
   logic             thinned;

   bg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_en),
      .tick_o (step_tick)
   );

   bg_downcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (step_tick),
      .ld_we_i  (reg_wr),
      .ld_val_i (reg_wdata[CNT_W-1:0]),
      .cnt_o    (cnt_val),
      .uf_o     (uf_pulse)
   );

   bg_thin #(.THIN_EN(THIN_EN)) u_thin (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (thin_sel),
      .pulse_i (uf_pulse),
      .pulse_o (thinned)
   );

   bg_postdiv #(.ASYNC_DIV(ASYNC_DIV), .SYNC_DIV(SYNC_DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (sync_mode),
      .pulse_i (thinned),
      .tick_o  (bit_tick)
   );

   // Write data bits above the timer width have no destination
   generate
      if (BUS_W > CNT_W) begin : g_hi
         logic unused_wr_hi;
         assign unused_wr_hi = ^reg_wdata[BUS_W-1:CNT_W];
      end
   endgenerate

   assign reg_rdata  = BUS_W'(cnt_val);
   assign ctr_pulse  = uf_pulse;
   assign thin_pulse = thinned;
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Property checker for baud_tick_gen, attached by bind.
module baud_tick_gen_chk #(
   parameter int unsigned CNT_W = baudgen_pkg::DEF_CNT_W,
   parameter int unsigned BUS_W = baudgen_pkg::DEF_BUS_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             thin_sel,
   input logic [BUS_W-1:0] reg_rdata,
   input logic             ctr_pulse,
   input logic             thin_pulse,
   input logic             bit_tick
);
   // R8
   rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata >> CNT_W) == '0);

   // R3
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ($stable(reg_rdata) && !ctr_pulse));

   // R4
   pulse_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_pulse |-> ($past(reg_rdata) == '0));

   // R4
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_pulse |=> !ctr_pulse);

   // R5
   thin_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !thin_sel |-> (thin_pulse == ctr_pulse));

   // R6
   thin_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thin_pulse |-> ctr_pulse);

   // R7
   bit_tick_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> thin_pulse);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_en     (run_en),
   .thin_sel   (thin_sel),
   .reg_rdata  (reg_rdata),
   .ctr_pulse  (ctr_pulse),
   .thin_pulse (thin_pulse),
   .bit_tick   (bit_tick)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        thin_sel = 1'b0;
   logic        sync_mode = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ctr_pulse, thin_pulse, bit_tick;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   baud_tick_gen u_baud_tick_gen (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .thin_sel(thin_sel),
      .sync_mode(sync_mode), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ctr_pulse(ctr_pulse), .thin_pulse(thin_pulse),
      .bit_tick(bit_tick)
   );

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; run_en = 1'b0; thin_sel = 1'b0; sync_mode = 1'b0;
      reg_wr = 1'b0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_reload(input logic [15:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // Clocks (counted at falling edges) until the next ctr_pulse
   task automatic wait_ctr(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!ctr_pulse && n < 40000);
   endtask

   initial begin
      int n;
      int v;
      int k;
      do_reset();
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", reg_rdata, 0);
      check("R1 pulses", {ctr_pulse, thin_pulse, bit_tick}, 0);

      // R2/R4 period sweep, reload 0 (reset value) first, then 1..15 and maximum
      run_en = 1'b1;
      for (int r = 0; r <= 16; r++) begin
         int rv;
         rv = (r == 16) ? 8191 : r;
         if (r != 0) write_reload(16'(rv));
         wait_ctr(n);
         wait_ctr(n);
         wait_ctr(n);
         check($sformatf("R2 period reload %0d", rv), n, 2 * (rv + 1));
         // R4 pulse lasts one clock and timer was just loaded with reload
         check("R8 rdata after underflow", reg_rdata, rv);
         @(negedge clk);
         check("R4 single-clock pulse", ctr_pulse, 0);
      end

      // R3/R9 stop, write with high bits set, timer undisturbed
      write_reload(16'd300);
      wait_ctr(n);
      repeat (77) @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      v = reg_rdata;
      write_reload(16'hE005);
      check("R9 timer undisturbed by write", reg_rdata, v);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check("R3 hold value", reg_rdata, v);
         check("R3 no pulse", ctr_pulse, 0);
      end
      check("R8 upper bits zero", reg_rdata[15:13], 0);
      run_en = 1'b1;
      wait_ctr(n);
      check("R9 old count runs out first", (n >= 2 * v) && (n <= 2 * v + 2), 1);
      check("R9 new reload loaded at underflow", reg_rdata, 5);
      wait_ctr(n);
      check("R9 high write bits ignored", n, 12);

      // R5 bypass of thinning
      write_reload(16'd2);
      wait_ctr(n); wait_ctr(n);
      for (int i = 0; i < 9; i++) begin
         wait_ctr(n);
         check("R5 all pulses pass", thin_pulse, 1);
      end

      // R6 thinning pattern, pass-pass-drop from setting thin_sel
      @(negedge clk);
      thin_sel = 1'b1;
      for (int i = 0; i < 30; i++) begin
         wait_ctr(n);
         check($sformatf("R6 pulse %0d", i), thin_pulse, (i % 3) != 2);
      end

      // R7 asynchronous divide by 16, synchronous by 4, then with thinning
      for (int m = 0; m < 3; m++) begin
         int dv;
         do_reset();
         sync_mode = (m != 0);
         thin_sel  = (m == 2);
         dv = (m == 0) ? 16 : 4;
         run_en = 1'b1;
         k = 0;
         for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (thin_pulse) begin
               k++;
               check($sformatf("R7 mode %0d pulse %0d", m, k), bit_tick, (k % dv) == 0);
            end else begin
               check("R7 no tick without pulse", bit_tick, 0);
            end
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule